// File: doc/BRIEF.md
# Bus-Strobe Handshake for a Multiplexed Converter

This block sits between a processor-style strobe bus and a successive-approximation conversion sequencer. A host drives active-low chip-select, write and read strobes. The low bits of a shared byte-wide data bus carry a channel-configuration code during writes, and the block puts the conversion result back on that bus during reads. An address is captured only while the read strobe is high. A write pulse starts a conversion. If the read strobe stays low for the whole write pulse, the write keeps the existing configuration and shows the last result on the bus instead. A completed read also starts a new conversion on the unchanged configuration.

All three strobes are brought into the system clock through a synchroniser chain, and edges are detected on the synchronised copies. Every strobe effect therefore takes place a fixed number of clock edges after the pin moves. An active-low completion flag tells the host that a new result is waiting. The sequencer side of the block has a one-cycle start pulse, a configuration code, a one-cycle done pulse and a result byte. The bus output is a data value plus an output-enable, so the tri-state driver sits outside the block. Example configuration codes are 0x00 for a differential pair on inputs 1 and 2, 0x02 for a differential pair on inputs 3 and 4, and 0x08 to 0x0F for single-ended inputs 1 to 8. The block only carries the code; it does not decode it.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, intr_no is 1, bus_oe_o is 0, conv_start_o is 0, conv_addr_o is 0 and bus_o is 0.
- R2: A write runs from write-strobe fall to write-strobe rise, with cs_ni low and rd_ni high. At the end of such a write, conv_addr_o takes the value bus_i held during the pulse, and conv_start_o pulses high for exactly one cycle. Both happen at the third rising clock edge after wr_ni rises.
- R3: A fall of wr_ni while cs_ni is low sets intr_no to 1 at the third rising clock edge after the pin falls. intr_no does not change at any earlier edge.
- R4: If rd_ni is low for the whole low period of wr_ni, conv_addr_o keeps its value whatever bus_i carries, and conv_start_o still pulses once at the end of the write. While rd_ni and cs_ni are low, bus_oe_o is 1 and bus_o shows the last result. The later rise of rd_ni starts no further conversion.
- R5: A one-cycle conv_done_i loads conv_result_i into the output latch and drives intr_no to 0 at the next rising edge. intr_no stays 0 until a qualified read or write clears it.
- R6: While cs_ni and rd_ni are both low, bus_oe_o is 1 and bus_o holds the latched result. A read also sets intr_no to 1. When rd_ni returns high, bus_oe_o returns to 0.
- R7: A read that starts with wr_ni high ends when rd_ni rises with cs_ni low. It then pulses conv_start_o once at the third rising edge after the rise, and conv_addr_o is unchanged.
- R8: While cs_ni is high, activity on wr_ni and rd_ni has no effect. conv_start_o stays 0, conv_addr_o and intr_no keep their values, and bus_oe_o stays 0.
- R9: If conv_done_i falls in the same cycle as a flag-clearing strobe edge, the done event wins and intr_no goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| bus_i | input | 5 | Low bits of the shared data bus, input side (configuration code) |
| bus_o | output | 8 | Data bus output value (latched result) |
| bus_oe_o | output | 1 | Data bus output enable; 0 means high impedance |
| intr_no | output | 1 | Result-ready flag, active low |
| conv_start_o | output | 1 | One-cycle conversion start to the sequencer |
| conv_addr_o | output | 5 | Channel-configuration code to the sequencer |
| conv_done_i | input | 1 | One-cycle conversion-complete pulse from the sequencer |
| conv_result_i | input | 8 | Conversion result from the sequencer |

## Verification
The completion flag has two sources that can land on the same clock edge: the sequencer's done pulse sets it low, and a synchronised strobe edge returns it high. The bench lowers the write strobe and counts the two synchroniser edges. It then raises conv_done_i in exactly the cycle in which the detected edge acts, so both events reach the flag register together. The outcome is judged by requiring intr_no to read 0 afterwards, and by a following read that must present the new result byte.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  // decoded strobe events, one cycle wide
  typedef struct packed {
    logic wr_fall;   // qualified write start
    logic wr_rise;   // qualified write end
    logic keep_cfg;  // read low through the whole write
    logic rd_clr;    // qualified read fall
    logic rd_start;  // qualified end of a plain read
  } strobe_ev_t;
endpackage

// File: rtl/adc_bus_sync.sv
module adc_bus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  // strobes are active low, so reset to inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_bus_strobe.sv
module adc_bus_strobe
  import adc_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_s_i,
  input  logic       wr_s_i,
  input  logic       rd_s_i,
  output strobe_ev_t ev_o,
  output logic       in_wr_o
);
  logic wr_q, rd_q, in_wr_q, in_rd_q, rd_held_q;
  logic rd_fall_plain, wr_any_rise, rd_any_rise;

  assign wr_any_rise   = ~wr_q & wr_s_i;
  assign rd_any_rise   = ~rd_q & rd_s_i;

  assign ev_o.wr_fall  = wr_q & ~wr_s_i & ~cs_s_i;
  assign ev_o.wr_rise  = wr_any_rise & in_wr_q & ~cs_s_i;
  assign ev_o.keep_cfg = rd_held_q & ~rd_s_i;
  assign ev_o.rd_clr   = rd_q & ~rd_s_i & ~cs_s_i;
  assign ev_o.rd_start = rd_any_rise & in_rd_q & ~cs_s_i;
  assign rd_fall_plain = ev_o.rd_clr & wr_s_i & ~in_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
      in_wr_q   <= 1'b0;
      in_rd_q   <= 1'b0;
      rd_held_q <= 1'b0;
    end else begin
      wr_q <= wr_s_i;
      rd_q <= rd_s_i;

      if (ev_o.wr_fall)    in_wr_q <= 1'b1;
      else if (wr_any_rise) in_wr_q <= 1'b0;

      // a write inside a read absorbs that read
      if (ev_o.wr_fall)     in_rd_q <= 1'b0;
      else if (rd_fall_plain) in_rd_q <= 1'b1;
      else if (rd_any_rise)   in_rd_q <= 1'b0;

      if (ev_o.wr_fall)           rd_held_q <= ~rd_s_i;
      else if (in_wr_q && rd_s_i) rd_held_q <= 1'b0;
    end
  end

  assign in_wr_o = in_wr_q;
endmodule

// File: rtl/adc_bus_regs.sv
module adc_bus_regs
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_ev_t        ev_i,
  input  logic              in_wr_i,
  input  logic              rd_s_i,
  input  logic [ADDR_W-1:0] bus_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_o,
  output logic [DATA_W-1:0] result_o,
  output logic              intr_no
);
  logic [ADDR_W-1:0] stage_q, addr_q;
  logic [DATA_W-1:0] result_q;
  logic              start_q, intr_nq;
  logic              cap_en, load_cfg;

  // address is accepted only while read is high inside the write window
  assign cap_en   = (ev_i.wr_fall | in_wr_i) & rd_s_i;
  assign load_cfg = ev_i.wr_rise & ~ev_i.keep_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      addr_q   <= '0;
      result_q <= '0;
      start_q  <= 1'b0;
      intr_nq  <= 1'b1;
    end else begin
      if (cap_en)   stage_q <= bus_i;
      if (load_cfg) addr_q  <= stage_q;
      start_q <= ev_i.wr_rise | ev_i.rd_start;
      if (done_i) result_q <= result_i;
      // a fresh result outranks a simultaneous clear
      if (done_i)                           intr_nq <= 1'b0;
      else if (ev_i.wr_fall | ev_i.rd_clr)  intr_nq <= 1'b1;
    end
  end

  assign addr_o   = addr_q;
  assign start_o  = start_q;
  assign result_o = result_q;
  assign intr_no  = intr_nq;
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic [ADDR_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              intr_no,
  output logic              conv_start_o,
  output logic [ADDR_W-1:0] conv_addr_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_result_i
);
  localparam int STROBES = 3;

  logic [STROBES-1:0] strb_s;
  logic               cs_s, wr_s, rd_s, in_wr;
  strobe_ev_t         ev;

  adc_bus_sync #(.W(STROBES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_ni, rd_ni}),
    .q_o   (strb_s)
  );
  assign {cs_s, wr_s, rd_s} = strb_s;

  adc_bus_strobe u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_s_i (cs_s),
    .wr_s_i (wr_s),
    .rd_s_i (rd_s),
    .ev_o   (ev),
    .in_wr_o(in_wr)
  );

  adc_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .in_wr_i (in_wr),
    .rd_s_i  (rd_s),
    .bus_i   (bus_i),
    .done_i  (conv_done_i),
    .result_i(conv_result_i),
    .addr_o  (conv_addr_o),
    .start_o (conv_start_o),
    .result_o(bus_o),
    .intr_no (intr_no)
  );

  assign bus_oe_o = ~cs_s & ~rd_s;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              bus_oe_o,
  input logic              intr_no,
  input logic              conv_start_o,
  input logic [ADDR_W-1:0] conv_addr_o,
  input logic              conv_done_i
);
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R2

  AST_ADDR_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(conv_addr_o) |-> conv_start_o); // R4

  AST_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> !intr_no); // R9

  AST_OE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!$past(cs_ni, 2) && !$past(rd_ni, 2))); // R6

  AST_CLEAR_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intr_no) |-> !$past(cs_ni, 3)); // R8

  AST_START_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !$past(cs_ni, 3)); // R8
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .rd_ni       (rd_ni),
  .bus_oe_o    (bus_oe_o),
  .intr_no     (intr_no),
  .conv_start_o(conv_start_o),
  .conv_addr_o (conv_addr_o),
  .conv_done_i (conv_done_i)
);

// File: tb/adc_bus_ctrl_test.sv
`timescale 1ns/1ps
module adc_bus_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, rd_ni = 1'b1;
  logic [4:0] bus_i = '0;
  logic [7:0] bus_o;
  logic       bus_oe_o, intr_no, conv_start_o;
  logic [4:0] conv_addr_o;
  logic       conv_done_i = 1'b0;
  logic [7:0] conv_result_i = '0;

  int total = 0, bad = 0, starts = 0;
  logic [4:0] exp_addr = '0;
  logic [7:0] exp_res = '0;

  always #10 clk_i = ~clk_i;

  adc_bus_ctrl uut (.*);

  always @(posedge clk_i) if (conv_start_o) starts <= starts + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic done_pulse(input logic [7:0] r);
    conv_done_i = 1'b1; conv_result_i = r;
    nclk(1);
    conv_done_i = 1'b0;
    exp_res = r;
  endtask

  // R2: write with read high
  task automatic do_write(input logic [4:0] d);
    cs_ni = 1'b0; bus_i = d;
    nclk(1);
    wr_ni = 1'b0;
    nclk(4);
    wr_ni = 1'b1;
    nclk(2);
    chk("R2 start early", conv_start_o, 0);
    nclk(1);
    exp_addr = d;
    chk("R2 start", conv_start_o, 1);
    chk("R2 addr", conv_addr_o, d);
    nclk(1);
    chk("R2 start width", conv_start_o, 0);
    cs_ni = 1'b1;
    nclk(2);
  endtask

  // R6 / R7: read then restart
  task automatic do_read();
    cs_ni = 1'b0;
    nclk(1);
    rd_ni = 1'b0;
    nclk(3);
    chk("R6 oe", bus_oe_o, 1);
    chk("R6 data", bus_o, exp_res);
    chk("R6 intr", intr_no, 1);
    rd_ni = 1'b1;
    nclk(3);
    chk("R7 start", conv_start_o, 1);
    chk("R7 addr", conv_addr_o, exp_addr);
    chk("R6 oe off", bus_oe_o, 0);
    nclk(1);
    chk("R7 start width", conv_start_o, 0);
    cs_ni = 1'b1;
    nclk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    nclk(3);
    chk("R1 intr", intr_no, 1);
    chk("R1 oe", bus_oe_o, 0);
    chk("R1 start", conv_start_o, 0);
    chk("R1 addr", conv_addr_o, 0);
    chk("R1 data", bus_o, 0);
    rst_ni = 1'b1;
    nclk(3);

    // R2 sweep over every configuration code
    for (int a = 0; a < 32; a++) do_write(5'((a * 13 + 7) % 32));

    // R5 / R6 / R7 sweep over result values
    for (int k = 0; k < 16; k++) begin
      done_pulse(8'((k * 17) ^ 8'h5A));
      chk("R5 intr low", intr_no, 0);
      nclk(6);
      chk("R5 intr held", intr_no, 0);
      do_read();
    end

    // R3 clear timing on write fall
    done_pulse(8'hC3);
    cs_ni = 1'b0; bus_i = 5'h0A;
    nclk(1);
    wr_ni = 1'b0;
    nclk(2);
    chk("R3 intr not yet", intr_no, 0);
    nclk(1);
    chk("R3 intr cleared", intr_no, 1);
    nclk(2);
    wr_ni = 1'b1;
    nclk(3);
    exp_addr = 5'h0A;
    chk("R3 addr", conv_addr_o, 5'h0A);
    cs_ni = 1'b1;
    nclk(3);

    // R4 write with read low throughout
    done_pulse(8'h96);
    cs_ni = 1'b0; rd_ni = 1'b0; bus_i = 5'h1F;
    nclk(1);
    wr_ni = 1'b0;
    nclk(4);
    chk("R4 oe", bus_oe_o, 1);
    chk("R4 data", bus_o, 8'h96);
    s0 = starts;
    wr_ni = 1'b1;
    nclk(3);
    chk("R4 start", conv_start_o, 1);
    chk("R4 addr kept", conv_addr_o, exp_addr);
    nclk(1);
    rd_ni = 1'b1;
    nclk(6);
    chk("R4 single start", starts - s0, 1);
    cs_ni = 1'b1;
    nclk(3);

    // R8 strobes ignored while deselected
    done_pulse(8'h3C);
    s0 = starts;
    begin
      int oe_seen = 0;
      bus_i = 5'h11;
      wr_ni = 1'b0; nclk(4); wr_ni = 1'b1; nclk(4);
      rd_ni = 1'b0;
      for (int i = 0; i < 5; i++) begin nclk(1); if (bus_oe_o) oe_seen++; end
      rd_ni = 1'b1; nclk(5);
      chk("R8 oe", oe_seen, 0);
    end
    chk("R8 no start", starts - s0, 0);
    chk("R8 addr", conv_addr_o, exp_addr);
    chk("R8 intr", intr_no, 0);

    // R9 done coincides with a clear
    cs_ni = 1'b0; bus_i = exp_addr;
    nclk(1);
    wr_ni = 1'b0;
    nclk(2);
    conv_done_i = 1'b1; conv_result_i = 8'hE7;
    nclk(1);
    conv_done_i = 1'b0; exp_res = 8'hE7;
    chk("R9 intr", intr_no, 0);
    nclk(2);
    wr_ni = 1'b1;
    nclk(4);
    cs_ni = 1'b1;
    nclk(2);
    chk("R9 intr kept", intr_no, 0);
    do_read();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule